// File: doc/BRIEF.md
# Multi-port message mailbox with full/empty handshake

This block carries short messages between the ports of a switch with up to eight ports. Each port owns a small set of outbound message registers and a small set of inbound message registers, four of each by default and 32 bits wide. A routing map ties each outbound register of each port to one inbound register anywhere in the switch, including on the sending port itself. When a port writes one of its outbound registers, the data goes straight to the inbound register the map selects. It lands there on the next clock edge, provided that register is empty.

Each inbound register has a full flag. While the flag is set, every new write aimed at that register is refused, whichever port sends it. The refused sender sees a sticky failure bit for the outbound register it used. Software in that port can retry once it has cleared the bit. The receiving port reads the data and the number of the port that sent it. It then writes a one to the register's clear input, which frees the slot. When several ports hit the same empty register in one cycle, the lowest-numbered port wins and the others are refused. This is how the block settles contention between many senders without a lock.

Each port has an interrupt output. It is the OR of that port's full flags, each gated by a mask bit. With the usual mask, only the first inbound register raises the interrupt, and the other three carry extra payload that comes with it.

Top module: `mbox_switch`

## Requirements
- R1: A write by port p to outbound register k (index on `ob_idx_i[p]`, 2 bits) is delivered to inbound register `route_slot_i[p][k]` (2 bits) of port `route_dst_i[p][k]` (3 bits). Any sender, register and destination combination is allowed.
- R2: An accepted write shows on `ib_full_o`, `ib_data_o` and `ib_src_o` of the destination after the first rising edge at which the write is presented.
- R3: While an inbound register is full, any write aimed at it is refused, and its data and source stay unchanged until it is cleared.
- R4: A refused write sets `ob_fail_o[p][k]` for the sending port p and the outbound register k it used, on the same edge at which an acceptance would have appeared.
- R5: A failure bit stays set until a one is written to its `ob_fail_clr_i` bit. A successful write leaves it unchanged. When a refusal and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: `ib_src_o` of an accepted message holds the number of the sending port.
- R7: A one on `ib_clr_i[d][j]` empties inbound register j of port d at the next edge. A write to that register in the same cycle is still refused, because refusal is judged against the full flag as it stood before the edge.
- R8: When two or more ports write the same empty inbound register in one cycle, the lowest-numbered port is accepted and every other one is refused.
- R9: `irq_o[d]` is high exactly when some inbound register j of port d is full and `ib_mask_i[d][j]` is 0. A mask bit of 1 blocks that register.
- R10: After reset all full flags and failure bits are 0, all inbound data and sources are 0, and all interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ob_wr_i | input | NP | Write strobe, one per port |
| ob_idx_i | input | NP x 2 | Outbound register index for each port's write |
| ob_data_i | input | NP x 32 | Write data for each port |
| route_dst_i | input | NP x NS x 3 | Destination port for each outbound register |
| route_slot_i | input | NP x NS x 2 | Destination inbound index for each outbound register |
| ob_fail_clr_i | input | NP x NS | Write-one-to-clear for the failure bits |
| ob_fail_o | output | NP x NS | Sticky refusal bits |
| ib_clr_i | input | NP x NS | Write-one-to-clear for the inbound full flags |
| ib_mask_i | input | NP x NS | Interrupt mask, 1 blocks |
| ib_full_o | output | NP x NS | Inbound full flags |
| ib_data_o | output | NP x NS x 32 | Inbound message data |
| ib_src_o | output | NP x NS x 3 | Sending port of each inbound message |
| irq_o | output | NP | Interrupt per port |

## Verification
The bench builds the block with its default parameters: eight ports, four registers per direction and 32-bit data. This fills the 3-bit source field up to port 7 and allows an eight-way collision on a single inbound register. Directed sequences cover the R8 collision, a refusal arriving together with a failure-bit clear, and a write arriving together with an inbound clear. A long random run then keeps changing routes, masks and clears while a bench model tracks every flag, data word and source.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DEF_PORTS = 8;
  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_DW    = 32;
endpackage

// File: rtl/mbox_route.sv
// Turns each port's write into a request on the inbound slot its route selects.
module mbox_route #(
  parameter int unsigned NP = mbox_pkg::DEF_PORTS,
  parameter int unsigned NS = mbox_pkg::DEF_SLOTS,
  localparam int unsigned PW = $clog2(NP),
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic [NP-1:0]                  wr_i,
  input  logic [NP-1:0][SW-1:0]          idx_i,
  input  logic [NP-1:0][NS-1:0][PW-1:0]  dst_i,
  input  logic [NP-1:0][NS-1:0][SW-1:0]  slot_i,
  output logic [NP*NS-1:0][NP-1:0]       req_o
);
  always_comb begin
    req_o = '0;
    for (int p = 0; p < NP; p++) begin
      if (wr_i[p] && int'(dst_i[p][idx_i[p]]) < NP && int'(slot_i[p][idx_i[p]]) < NS)
        req_o[int'(dst_i[p][idx_i[p]]) * NS + int'(slot_i[p][idx_i[p]])][p] = 1'b1;
    end
  end
endmodule

// File: rtl/mbox_arb.sv
// Fixed-priority grant for one inbound slot; nothing is granted while full.
module mbox_arb #(
  parameter int unsigned NP = mbox_pkg::DEF_PORTS
) (
  input  logic [NP-1:0] req_i,
  input  logic          full_i,
  output logic [NP-1:0] gnt_o,
  output logic [NP-1:0] nack_o
);
  logic taken;
  always_comb begin
    gnt_o = '0;
    taken = full_i;
    for (int p = 0; p < NP; p++) begin
      if (req_i[p] && !taken) begin
        gnt_o[p] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
  assign nack_o = req_i & ~gnt_o;
endmodule

// File: rtl/mbox_inbox.sv
// Inbound registers of one port: data, source, full flag, interrupt.
module mbox_inbox #(
  parameter int unsigned NP = mbox_pkg::DEF_PORTS,
  parameter int unsigned NS = mbox_pkg::DEF_SLOTS,
  parameter int unsigned DW = mbox_pkg::DEF_DW,
  localparam int unsigned PW = $clog2(NP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NS-1:0]          acc_i,
  input  logic [NS-1:0][DW-1:0]  acc_data_i,
  input  logic [NS-1:0][PW-1:0]  acc_src_i,
  input  logic [NS-1:0]          clr_i,
  input  logic [NS-1:0]          mask_i,
  output logic [NS-1:0]          full_o,
  output logic [NS-1:0][DW-1:0]  data_o,
  output logic [NS-1:0][PW-1:0]  src_o,
  output logic                   irq_o
);
  for (genvar j = 0; j < NS; j++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_o[j] <= 1'b0;
        data_o[j] <= '0;
        src_o[j]  <= '0;
      end else begin
        full_o[j] <= (full_o[j] & ~clr_i[j]) | acc_i[j];
        if (acc_i[j]) begin
          data_o[j] <= acc_data_i[j];
          src_o[j]  <= acc_src_i[j];
        end
      end
    end
  end

  assign irq_o = |(full_o & ~mask_i);
endmodule

// File: rtl/mbox_switch.sv
module mbox_switch #(
  parameter int unsigned NP = mbox_pkg::DEF_PORTS,
  parameter int unsigned NS = mbox_pkg::DEF_SLOTS,
  parameter int unsigned DW = mbox_pkg::DEF_DW,
  localparam int unsigned PW = $clog2(NP),
  localparam int unsigned SW = $clog2(NS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NP-1:0]                    ob_wr_i,
  input  logic [NP-1:0][SW-1:0]            ob_idx_i,
  input  logic [NP-1:0][DW-1:0]            ob_data_i,
  input  logic [NP-1:0][NS-1:0][PW-1:0]    route_dst_i,
  input  logic [NP-1:0][NS-1:0][SW-1:0]    route_slot_i,
  input  logic [NP-1:0][NS-1:0]            ob_fail_clr_i,
  output logic [NP-1:0][NS-1:0]            ob_fail_o,
  input  logic [NP-1:0][NS-1:0]            ib_clr_i,
  input  logic [NP-1:0][NS-1:0]            ib_mask_i,
  output logic [NP-1:0][NS-1:0]            ib_full_o,
  output logic [NP-1:0][NS-1:0][DW-1:0]    ib_data_o,
  output logic [NP-1:0][NS-1:0][PW-1:0]    ib_src_o,
  output logic [NP-1:0]                    irq_o
);
  localparam int unsigned NSLOT = NP * NS;

  logic [NSLOT-1:0][NP-1:0] slot_req, slot_gnt, slot_nack;
  logic [NSLOT-1:0]         slot_acc;
  logic [NSLOT-1:0][DW-1:0] slot_wdata;
  logic [NSLOT-1:0][PW-1:0] slot_wsrc;
  logic [NP-1:0]            sender_nack;
  logic [NP-1:0][NS-1:0]    fail_set;

  mbox_route #(.NP(NP), .NS(NS)) u_route (
    .wr_i   (ob_wr_i),
    .idx_i  (ob_idx_i),
    .dst_i  (route_dst_i),
    .slot_i (route_slot_i),
    .req_o  (slot_req)
  );

  for (genvar d = 0; d < NP; d++) begin : g_dst
    for (genvar j = 0; j < NS; j++) begin : g_slot
      mbox_arb #(.NP(NP)) u_arb (
        .req_i  (slot_req[d*NS+j]),
        .full_i (ib_full_o[d][j]),
        .gnt_o  (slot_gnt[d*NS+j]),
        .nack_o (slot_nack[d*NS+j])
      );
    end

    mbox_inbox #(.NP(NP), .NS(NS), .DW(DW)) u_inbox (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .acc_i      (slot_acc[d*NS +: NS]),
      .acc_data_i (slot_wdata[d*NS +: NS]),
      .acc_src_i  (slot_wsrc[d*NS +: NS]),
      .clr_i      (ib_clr_i[d]),
      .mask_i     (ib_mask_i[d]),
      .full_o     (ib_full_o[d]),
      .data_o     (ib_data_o[d]),
      .src_o      (ib_src_o[d]),
      .irq_o      (irq_o[d])
    );
  end

  // Grants are one-hot, so an OR over senders selects the winner.
  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      slot_acc[s]   = |slot_gnt[s];
      slot_wdata[s] = '0;
      slot_wsrc[s]  = '0;
      for (int p = 0; p < NP; p++) begin
        if (slot_gnt[s][p]) begin
          slot_wdata[s] = slot_wdata[s] | ob_data_i[p];
          slot_wsrc[s]  = slot_wsrc[s] | PW'(p);
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      sender_nack[p] = 1'b0;
      for (int s = 0; s < NSLOT; s++) sender_nack[p] = sender_nack[p] | slot_nack[s][p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_src
    assign fail_set[p] = sender_nack[p] ? (NS'(1) << ob_idx_i[p]) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ob_fail_o[p] <= '0;
      else         ob_fail_o[p] <= (ob_fail_o[p] & ~ob_fail_clr_i[p]) | fail_set[p];
    end
  end
endmodule

// File: rtl/mbox_switch_chk.sv
module mbox_switch_chk #(
  parameter int unsigned NP = mbox_pkg::DEF_PORTS,
  parameter int unsigned NS = mbox_pkg::DEF_SLOTS,
  parameter int unsigned DW = mbox_pkg::DEF_DW,
  localparam int unsigned PW = $clog2(NP),
  localparam int unsigned SW = $clog2(NS)
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NP-1:0]                    ob_wr_i,
  input logic [NP-1:0][SW-1:0]            ob_idx_i,
  input logic [NP-1:0][DW-1:0]            ob_data_i,
  input logic [NP-1:0][NS-1:0][PW-1:0]    route_dst_i,
  input logic [NP-1:0][NS-1:0][SW-1:0]    route_slot_i,
  input logic [NP-1:0][NS-1:0]            ob_fail_clr_i,
  input logic [NP-1:0][NS-1:0]            ob_fail_o,
  input logic [NP-1:0][NS-1:0]            ib_clr_i,
  input logic [NP-1:0][NS-1:0]            ib_mask_i,
  input logic [NP-1:0][NS-1:0]            ib_full_o,
  input logic [NP-1:0][NS-1:0][DW-1:0]    ib_data_o,
  input logic [NP-1:0][NS-1:0][PW-1:0]    ib_src_o,
  input logic [NP-1:0]                    irq_o
);
  for (genvar d = 0; d < NP; d++) begin : g_p
    assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|ib_full_o[d]) |-> !irq_o[d]);

    for (genvar j = 0; j < NS; j++) begin : g_s
      assert_full_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ib_full_o[d][j] && !ib_clr_i[d][j] |=> ib_full_o[d][j]);
      assert_data_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ib_full_o[d][j] && !ib_clr_i[d][j] |=> $stable(ib_data_o[d][j]) && $stable(ib_src_o[d][j]));
      assert_clear_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ib_full_o[d][j] && ib_clr_i[d][j] |=> !ib_full_o[d][j]);
      assert_fill_needs_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ib_full_o[d][j]) |-> $past(|ob_wr_i));
      assert_fail_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ob_fail_o[d][j] && !ob_fail_clr_i[d][j] |=> ob_fail_o[d][j]);
      assert_fail_needs_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ob_fail_o[d][j]) |-> $past(ob_wr_i[d]));
    end
  end
endmodule

bind mbox_switch mbox_switch_chk #(.NP(NP), .NS(NS), .DW(DW)) u_chk (.*);

// File: tb/tb_mbox_switch.sv
module tb_mbox_switch;
  localparam int NP = 8, NS = 4, DW = 32, PW = 3, SW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic [NP-1:0]                 wr;
  logic [NP-1:0][SW-1:0]         idx;
  logic [NP-1:0][DW-1:0]         data;
  logic [NP-1:0][NS-1:0][PW-1:0] rdst;
  logic [NP-1:0][NS-1:0][SW-1:0] rslot;
  logic [NP-1:0][NS-1:0]         fclr, clr, mask;
  logic [NP-1:0][NS-1:0]         fail_o, full_o;
  logic [NP-1:0][NS-1:0][DW-1:0] idata_o;
  logic [NP-1:0][NS-1:0][PW-1:0] isrc_o;
  logic [NP-1:0]                 irq_o;

  logic [NP-1:0][NS-1:0]         m_full, m_fail;
  logic [NP-1:0][NS-1:0][DW-1:0] m_data;
  logic [NP-1:0][NS-1:0][PW-1:0] m_src;

  int checks = 0, fails = 0;

  mbox_switch #(.NP(NP), .NS(NS), .DW(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ob_wr_i(wr), .ob_idx_i(idx), .ob_data_i(data),
    .route_dst_i(rdst), .route_slot_i(rslot), .ob_fail_clr_i(fclr), .ob_fail_o(fail_o),
    .ib_clr_i(clr), .ib_mask_i(mask), .ib_full_o(full_o), .ib_data_o(idata_o),
    .ib_src_o(isrc_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic exp_irq(input int d);
    return |(m_full[d] & ~mask[d]);
  endfunction

  task automatic compare_all();
    for (int d = 0; d < NP; d++) begin
      chk($sformatf("R2/R3/R7 full port %0d", d), 128'(full_o[d]), 128'(m_full[d]));
      chk($sformatf("R1/R3 data port %0d", d), 128'(idata_o[d]), 128'(m_data[d]));
      chk($sformatf("R6 source port %0d", d), 128'(isrc_o[d]), 128'(m_src[d]));
      chk($sformatf("R4/R5/R8 fail port %0d", d), 128'(fail_o[d]), 128'(m_fail[d]));
      chk($sformatf("R9 irq port %0d", d), 128'(irq_o[d]), 128'(exp_irq(d)));
    end
  endtask

  // Model one edge from current stimulus, then apply it and compare.
  task automatic step();
    logic [NP-1:0][NS-1:0] granted, nack;
    granted = '0;
    nack = '0;
    for (int p = 0; p < NP; p++) begin
      if (wr[p]) begin
        int d, j;
        d = int'(rdst[p][idx[p]]);
        j = int'(rslot[p][idx[p]]);
        if (!m_full[d][j] && !granted[d][j]) begin
          granted[d][j] = 1'b1;
          m_data[d][j]  = data[p];
          m_src[d][j]   = PW'(p);
        end else nack[p][idx[p]] = 1'b1;
      end
    end
    m_full = (m_full & ~clr) | granted;
    m_fail = (m_fail & ~fclr) | nack;
    @(posedge clk_i);
    @(negedge clk_i);
    wr = '0; clr = '0; fclr = '0;
    compare_all();
  endtask

  task automatic idle_in();
    wr = '0; idx = '0; data = '0; clr = '0; fclr = '0;
  endtask

  logic done = 1'b0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    idle_in();
    rdst = '0; rslot = '0;
    mask = {NP{4'b1110}};
    m_full = '0; m_fail = '0; m_data = '0; m_src = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk("R10 full after reset", 128'(full_o), 128'(0));
    chk("R10 fail after reset", 128'(fail_o), 128'(0));
    chk("R10 irq after reset", 128'(irq_o), 128'(0));
    chk("R10 data after reset", 128'(idata_o[0]), 128'(0));

    // R8: every port writes outbound 0, all routed to port 0 slot 0
    for (int p = 0; p < NP; p++) begin
      rdst[p][0] = 3'd0; rslot[p][0] = 2'd0;
      wr[p] = 1'b1; idx[p] = 2'd0; data[p] = 32'hA000_0000 + p;
    end
    step();
    chk("R8 winner source", 128'(isrc_o[0][0]), 128'(0));
    chk("R8 winner data", 128'(idata_o[0][0]), 128'(32'hA000_0000));
    for (int p = 0; p < NP; p++)
      chk($sformatf("R8 loser fail port %0d", p), 128'(fail_o[p][0]), 128'(p != 0));
    chk("R9 irq on slot 0 arrival", 128'(irq_o[0]), 128'(1));

    // R3/R4/R5: write to full slot while all fail bits are cleared
    wr[0] = 1'b1; idx[0] = 2'd0; data[0] = 32'hDEAD_BEEF;
    fclr = {NP{4'b1111}};
    step();
    chk("R3 full slot keeps data", 128'(idata_o[0][0]), 128'(32'hA000_0000));
    chk("R5 set wins over clear", 128'(fail_o[0][0]), 128'(1));
    chk("R5 other fail cleared", 128'(fail_o[1][0]), 128'(0));

    // R7: inbound clear and a write in the same cycle
    clr[0][0] = 1'b1;
    wr[5] = 1'b1; idx[5] = 2'd0; data[5] = 32'h5555_0005;
    step();
    chk("R7 clear empties slot", 128'(full_o[0][0]), 128'(0));
    chk("R7 same-cycle write refused", 128'(fail_o[5][0]), 128'(1));

    // R5/R6: successful write leaves the fail bit set
    wr[5] = 1'b1; idx[5] = 2'd0; data[5] = 32'h5555_0006;
    step();
    chk("R6 source of accepted", 128'(isrc_o[0][0]), 128'(5));
    chk("R5 success keeps fail", 128'(fail_o[5][0]), 128'(1));

    // R1/R9: port 2 outbound 3 -> port 6 slot 1, irq masked then unmasked
    rdst[2][3] = 3'd6; rslot[2][3] = 2'd1;
    mask[6] = 4'b1111;
    wr[2] = 1'b1; idx[2] = 2'd3; data[2] = 32'h0C0F_FEE2;
    step();
    chk("R1 routed delivery", 128'(idata_o[6][1]), 128'(32'h0C0F_FEE2));
    chk("R9 masked irq", 128'(irq_o[6]), 128'(0));
    mask[6] = 4'b1101;
    #1;
    chk("R9 unmasked irq", 128'(irq_o[6]), 128'(1));

    // Random phase
    for (int c = 0; c < 3000; c++) begin
      if (c % 250 == 0) begin
        for (int p = 0; p < NP; p++)
          for (int k = 0; k < NS; k++) begin
            rdst[p][k]  = PW'($urandom_range(0, NP - 1));
            rslot[p][k] = SW'($urandom_range(0, NS - 1));
          end
        mask = NP*NS'($urandom);
      end
      for (int p = 0; p < NP; p++) begin
        wr[p]   = ($urandom_range(0, 2) == 0);
        idx[p]  = SW'($urandom_range(0, NS - 1));
        data[p] = $urandom;
        for (int k = 0; k < NS; k++) begin
          clr[p][k]  = ($urandom_range(0, 3) == 0);
          fclr[p][k] = ($urandom_range(0, 7) == 0);
        end
      end
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule